// File: doc/BRIEF.md
# CPU Packet Endpoint Buffer

This block connects a 16-bit register bus to a word-wide packet link. Software builds an outgoing packet by writing words one at a time into a transmit buffer, then commits everything written since the last commit as a single packet by setting a flush bit in the control register. The committed words leave on the link in order, and the final word is marked. Every packet carries a four-word header: target address, source address, a word holding a type byte and a byte count, and a payload length in bytes. Payload words follow the header.

Incoming link words are collected per packet in a receive buffer. A packet becomes visible to software only once its last word has arrived, its length field matches its word count, and every one of its words fitted in the buffer. Software pops received words through a data register. The status register shows whether a word is waiting and whether the head word is the first or the last of its packet. Error conditions are held in sticky status bits that software clears by writing ones to them. An interrupt word combines two buffer levels and two one-shot events, and an interrupt pin is raised while software has something to service.

Register offsets on `cpu_addr`: 0 status, 1 control, 2 transmit data (write), 3 receive data (read), 4 device address, 5 interrupt word. A read returns its data on `cpu_rdata` on the clock edge after `cpu_rd` is sampled.

Top module: `pkt_endpoint`

## Requirements
- R1: After reset the status word reads 0x0000, the control word reads 0x0000, the interrupt word reads 0x0020 and the `irq` pin is low.
- R2: Words written to offset 2 are held until a control write with bit 15 set. They then leave on `tx_data` in write order with `tx_last` on the final word, and each word stays stable while `tx_ready` is low. Status bit 0 is set while uncommitted words exist, and status bit 1 is set while a committed packet is still being sent.
- R3: Status bit 2 is set while the transmit buffer is full. A transmit data write while the buffer is full is discarded and sets status bit 3. A flush while a packet is still being sent is ignored and sets status bit 3.
- R4: Control bit 12 enables reception. Packets that arrive while it is clear are discarded and set no flag.
- R5: A received packet is exposed only after its last word is accepted. Status bit 15 shows that a word is waiting, bit 13 that the head word is the first of its packet, and bit 12 that it is the last.
- R6: Each read of offset 3 returns the head word and removes it. A read of offset 3 with no word waiting returns 0 and changes nothing.
- R7: A packet whose word count differs from 4 + ceil(L/2), where L is its fourth word, is discarded whole and sets status bit 8.
- R8: A packet that does not fit in the free receive space is discarded whole and sets status bit 11. The packets already queued are kept.
- R9: Status bits 3, 8 and 11 are sticky. Writing a 1 to a bit clears it, and writing 0 leaves it unchanged. A new error in the same cycle as the clear keeps the bit set.
- R10: Interrupt word bit 5 is set while the transmit buffer is empty, and bit 8 while a received word is waiting. Bit 6 records a finished transmission and bit 7 a newly exposed packet; both clear on a read of the interrupt word unless a new event arrives in that same cycle. `irq` is high while bit 6, 7 or 8 is set.
- R11: The device address register at offset 4 reads back the last value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe |
| cpu_addr | input | 3 | Register offset |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data, registered |
| tx_valid | output | 1 | Outgoing word valid |
| tx_data | output | 16 | Outgoing word |
| tx_last | output | 1 | Outgoing word ends its packet |
| tx_ready | input | 1 | Link accepts the outgoing word |
| rx_valid | input | 1 | Incoming word valid |
| rx_data | input | 16 | Incoming word |
| rx_last | input | 1 | Incoming word ends its packet |
| irq | output | 1 | Interrupt request |

## Verification
The conflict of interest is a read of the interrupt word that lands on the same edge where a transmission completes and the looped-back packet is exposed: the read clear and the two event sets then act on the same flops. The bench commits a six-word packet through the loopback and counts edges from the flush so that its interrupt read is sampled on exactly the completion edge. That read must return the pre-edge value (no events, transmit buffer not yet empty), and a following read must still show both events. A property also requires that an interrupt read with no new packet leaves the receive event cleared.

// File: rtl/ep_pkg.sv
package ep_pkg;
  localparam int DW = 16;

  // register offsets
  localparam logic [2:0] A_STATUS = 3'd0;
  localparam logic [2:0] A_CTRL   = 3'd1;
  localparam logic [2:0] A_TXD    = 3'd2;
  localparam logic [2:0] A_RXD    = 3'd3;
  localparam logic [2:0] A_DEV    = 3'd4;
  localparam logic [2:0] A_IRQ    = 3'd5;

  // status bits
  localparam int S_BUILD  = 0;
  localparam int S_BUSY   = 1;
  localparam int S_FULL   = 2;
  localparam int S_TXERR  = 3;
  localparam int S_LENERR = 8;
  localparam int S_DROP   = 11;
  localparam int S_LAST   = 12;
  localparam int S_FIRST  = 13;
  localparam int S_AVAIL  = 15;

  // control bits
  localparam int C_RXEN  = 12;
  localparam int C_FLUSH = 15;

  // interrupt word bits
  localparam int I_TXFREE  = 5;
  localparam int I_TXDONE  = 6;
  localparam int I_RXNEW   = 7;
  localparam int I_RXAVAIL = 8;
endpackage

// File: rtl/ep_ram.sv
module ep_ram #(
  parameter int W  = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/ep_tx.sv
module ep_tx #(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          flush,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_last,
  input  logic          out_ready,
  output logic          full,
  output logic          empty,
  output logic          building,
  output logic          busy,
  output logic          err,
  output logic          done
);
  localparam logic [AW:0] ONE = (AW+1)'(1);

  logic [AW:0] wp, rp, pend, rem, used;
  logic        push_ok, hs, flush_go;

  assign used     = wp - rp;
  assign full     = used[AW];
  assign empty    = (used == '0);
  assign push_ok  = push & ~full;
  assign out_valid = (rem != '0);
  assign out_last  = (rem == ONE);
  assign hs       = out_valid & out_ready;
  assign flush_go = flush & (rem == '0) & (pend != '0);
  assign err      = (push & full) | (flush & (rem != '0));
  assign done     = hs & out_last;
  assign building = (pend != '0);
  assign busy     = out_valid;

  ep_ram #(.W(DW), .AW(AW)) u_mem (
    .clk(clk), .we(push_ok), .waddr(wp[AW-1:0]), .wdata(push_data),
    .raddr(rp[AW-1:0]), .rdata(out_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wp   <= '0;
      rp   <= '0;
      pend <= '0;
      rem  <= '0;
    end else begin
      if (push_ok) wp <= wp + ONE;
      if (hs)      rp <= rp + ONE;
      if (flush_go) begin
        pend <= '0;
        rem  <= pend;
      end else begin
        if (push_ok) pend <= pend + ONE;
        if (hs)      rem  <= rem - ONE;
      end
    end
  end
endmodule

// File: rtl/ep_rx.sv
module ep_rx #(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          in_last,
  input  logic          pop,
  output logic [DW-1:0] head_data,
  output logic          head_first,
  output logic          head_last,
  output logic          avail,
  output logic          pkt_ok,
  output logic          pkt_drop,
  output logic          pkt_badlen
);
  localparam int EW = DW + 2;
  localparam int CW = DW + 1;
  localparam logic [AW:0] ONE = (AW+1)'(1);

  logic [AW:0]   wc, wt, rp, used;
  logic [CW-1:0] cnt, total, expect_n;
  logic [DW-1:0] len_q, len_eff;
  logic          off_q, ovf_q, off_now, ovf_now, wr, fin, badlen;
  logic [EW-1:0] head_ent;

  assign used     = wt - rp;
  assign off_now  = off_q | ~en;
  assign ovf_now  = ovf_q | used[AW];
  assign wr       = in_valid & ~off_now & ~ovf_now;
  assign len_eff  = (cnt == CW'(3)) ? in_data : len_q;
  assign total    = cnt + CW'(1);
  assign expect_n = CW'(4) + ((CW'(len_eff) + CW'(1)) >> 1);
  assign badlen   = (total != expect_n);
  assign fin      = in_valid & in_last;

  assign pkt_ok     = fin & ~off_now & ~ovf_now & ~badlen;
  assign pkt_drop   = fin & ~off_now & ovf_now;
  assign pkt_badlen = fin & ~off_now & ~ovf_now & badlen;

  assign avail      = (wc != rp);
  assign head_data  = head_ent[DW-1:0];
  assign head_last  = head_ent[DW];
  assign head_first = head_ent[DW+1];

  ep_ram #(.W(EW), .AW(AW)) u_mem (
    .clk(clk), .we(wr), .waddr(wt[AW-1:0]),
    .wdata({(cnt == '0), in_last, in_data}),
    .raddr(rp[AW-1:0]), .rdata(head_ent)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wc    <= '0;
      wt    <= '0;
      rp    <= '0;
      cnt   <= '0;
      len_q <= '0;
      off_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      if (pop && avail) rp <= rp + ONE;
      if (in_valid) begin
        if (in_last) begin
          cnt   <= '0;
          off_q <= 1'b0;
          ovf_q <= 1'b0;
          if (pkt_ok) begin
            wt <= wt + ONE;
            wc <= wt + ONE;
          end else begin
            wt <= wc;
          end
        end else begin
          cnt   <= total;
          off_q <= off_now;
          ovf_q <= ovf_now;
          if (cnt == CW'(3)) len_q <= in_data;
          if (wr) wt <= wt + ONE;
        end
      end
    end
  end
endmodule

// File: rtl/pkt_endpoint.sv
module pkt_endpoint
  import ep_pkg::*;
#(
  parameter int TX_AW = 4,
  parameter int RX_AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_wr,
  input  logic          cpu_rd,
  input  logic [2:0]    cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  output logic          tx_last,
  input  logic          tx_ready,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_last,
  output logic          irq
);
  logic          en_q, ev_tx, ev_rx;
  logic [2:0]    err_q, err_set, err_clr;
  logic [DW-1:0] dev_q, rdata_q, rd_mux, status_w, irq_w;
  logic          tx_push, tx_flush, tx_full, tx_empty, tx_build, tx_busy, tx_err, tx_done;
  logic          rx_pop, rx_avail, rx_first, rx_lastw, rx_ok, rx_drop, rx_badlen;
  logic [DW-1:0] rx_head;
  logic          irq_rd;

  assign tx_push  = cpu_wr & (cpu_addr == A_TXD);
  assign tx_flush = cpu_wr & (cpu_addr == A_CTRL) & cpu_wdata[C_FLUSH];
  assign rx_pop   = cpu_rd & (cpu_addr == A_RXD);
  assign irq_rd   = cpu_rd & (cpu_addr == A_IRQ);

  ep_tx #(.DW(DW), .AW(TX_AW)) u_tx (
    .clk(clk), .rst(rst), .push(tx_push), .push_data(cpu_wdata), .flush(tx_flush),
    .out_valid(tx_valid), .out_data(tx_data), .out_last(tx_last), .out_ready(tx_ready),
    .full(tx_full), .empty(tx_empty), .building(tx_build), .busy(tx_busy),
    .err(tx_err), .done(tx_done)
  );

  ep_rx #(.DW(DW), .AW(RX_AW)) u_rx (
    .clk(clk), .rst(rst), .en(en_q), .in_valid(rx_valid), .in_data(rx_data),
    .in_last(rx_last), .pop(rx_pop), .head_data(rx_head), .head_first(rx_first),
    .head_last(rx_lastw), .avail(rx_avail), .pkt_ok(rx_ok), .pkt_drop(rx_drop),
    .pkt_badlen(rx_badlen)
  );

  // sticky error flags: [0] transmit, [1] length, [2] dropped
  assign err_set = {rx_drop, rx_badlen, tx_err};
  assign err_clr = (cpu_wr && cpu_addr == A_STATUS)
                   ? {cpu_wdata[S_DROP], cpu_wdata[S_LENERR], cpu_wdata[S_TXERR]} : 3'b000;

  always_comb begin
    status_w            = '0;
    status_w[S_BUILD]   = tx_build;
    status_w[S_BUSY]    = tx_busy;
    status_w[S_FULL]    = tx_full;
    status_w[S_TXERR]   = err_q[0];
    status_w[S_LENERR]  = err_q[1];
    status_w[S_DROP]    = err_q[2];
    status_w[S_LAST]    = rx_avail & rx_lastw;
    status_w[S_FIRST]   = rx_avail & rx_first;
    status_w[S_AVAIL]   = rx_avail;

    irq_w               = '0;
    irq_w[I_TXFREE]     = tx_empty;
    irq_w[I_TXDONE]     = ev_tx;
    irq_w[I_RXNEW]      = ev_rx;
    irq_w[I_RXAVAIL]    = rx_avail;

    rd_mux = '0;
    case (cpu_addr)
      A_STATUS: rd_mux = status_w;
      A_CTRL:   rd_mux[C_RXEN] = en_q;
      A_RXD:    rd_mux = rx_avail ? rx_head : '0;
      A_DEV:    rd_mux = dev_q;
      A_IRQ:    rd_mux = irq_w;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      dev_q   <= '0;
      err_q   <= '0;
      ev_tx   <= 1'b0;
      ev_rx   <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (cpu_wr && cpu_addr == A_CTRL) en_q  <= cpu_wdata[C_RXEN];
      if (cpu_wr && cpu_addr == A_DEV)  dev_q <= cpu_wdata;
      err_q   <= (err_q & ~err_clr) | err_set;
      ev_tx   <= tx_done | (ev_tx & ~irq_rd);
      ev_rx   <= rx_ok   | (ev_rx & ~irq_rd);
      rdata_q <= cpu_rd ? rd_mux : '0;
    end
  end

  assign cpu_rdata = rdata_q;
  assign irq       = ev_tx | ev_rx | rx_avail;
endmodule

// File: rtl/ep_checker.sv
module ep_checker
  import ep_pkg::*;
(
  input logic          clk,
  input logic          rst,
  input logic          cpu_wr,
  input logic          cpu_rd,
  input logic [2:0]    cpu_addr,
  input logic [DW-1:0] cpu_wdata,
  input logic [DW-1:0] cpu_rdata,
  input logic          tx_valid,
  input logic [DW-1:0] tx_data,
  input logic          tx_ready,
  input logic          rx_avail,
  input logic [2:0]    err_q,
  input logic          ev_rx,
  input logic          rx_ok
);
  // R2: a stalled outgoing word is held
  assert_tx_hold_R2: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  // R5: an exposed word stays exposed until software pops it
  assert_rx_keep_R5: assert property (@(posedge clk) disable iff (rst)
    rx_avail && !(cpu_rd && cpu_addr == A_RXD) |=> rx_avail);

  // R6: reading an empty receive queue yields zero
  assert_rx_empty_zero_R6: assert property (@(posedge clk) disable iff (rst)
    cpu_rd && cpu_addr == A_RXD && !rx_avail |=> cpu_rdata == '0);

  // R9: writing zero to the dropped flag keeps it
  assert_w1c_keep_R9: assert property (@(posedge clk) disable iff (rst)
    cpu_wr && cpu_addr == A_STATUS && !cpu_wdata[S_DROP] && err_q[2] |=> err_q[2]);

  // R10: an interrupt read with no new packet clears the receive event
  assert_irq_clear_R10: assert property (@(posedge clk) disable iff (rst)
    cpu_rd && cpu_addr == A_IRQ && !rx_ok |=> !ev_rx);
endmodule

bind pkt_endpoint ep_checker u_chk (.*);

// File: tb/tb_pkt_endpoint.sv
module tb_pkt_endpoint;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        cpu_wr, cpu_rd;
  logic [2:0]  cpu_addr;
  logic [15:0] cpu_wdata, cpu_rdata;
  logic        tx_valid, tx_last, tx_ready;
  logic [15:0] tx_data;
  logic        rx_valid, rx_last;
  logic [15:0] rx_data;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // loopback of the link
  assign rx_valid = tx_valid & tx_ready;
  assign rx_data  = tx_data;
  assign rx_last  = tx_last;

  pkt_endpoint dut (
    .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_last(rx_last), .irq(irq)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      n_tests = n_tests + 1;
      n_fail  = n_fail + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
    n_tests = n_tests + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(posedge clk); @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    cpu_rd = 1'b1; cpu_addr = a;
    @(posedge clk); @(negedge clk);
    d = cpu_rdata;
    cpu_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic test_reset;
    logic [15:0] v;
    rd(3'd0, v); chk("R1 status after reset", v, 16'h0000);
    rd(3'd1, v); chk("R1 control after reset", v, 16'h0000);
    rd(3'd5, v); chk("R1 interrupt word after reset", v, 16'h0020);
    chk("R1 irq pin after reset", {15'd0, irq}, 16'h0000);
    rd(3'd3, v); chk("R6 empty receive read", v, 16'h0000);
    wr(3'd4, 16'h00AB);
    rd(3'd4, v); chk("R11 device address readback", v, 16'h00AB);
  endtask

  task automatic test_loop;
    logic [15:0] v;
    logic [15:0] w [6] = '{16'h0001, 16'h0002, 16'h0100, 16'h0003, 16'h1111, 16'h2222};
    wr(3'd1, 16'h1000);
    rd(3'd5, v);
    for (int k = 0; k < 6; k++) wr(3'd2, w[k]);
    rd(3'd0, v); chk("R2 building before flush", v, 16'h0001);
    wr(3'd1, 16'h9000);
    idle(15);
    rd(3'd5, v); chk("R10 events after loopback", v, 16'h01E0);
    chk("R10 irq pin with packet", {15'd0, irq}, 16'h0001);
    rd(3'd5, v); chk("R10 events cleared on read", v, 16'h0120);
    rd(3'd0, v); chk("R5 head is first word", v, 16'hA000);
    for (int k = 0; k < 6; k++) begin
      if (k == 5) begin
        rd(3'd0, v); chk("R5 head is last word", v, 16'h9000);
      end
      rd(3'd3, v); chk("R2 R6 received word in order", v, w[k]);
    end
    rd(3'd0, v); chk("R6 queue empty after pops", v, 16'h0000);
    rd(3'd3, v); chk("R6 empty read returns zero", v, 16'h0000);
  endtask

  task automatic test_badlen;
    logic [15:0] v;
    logic [15:0] w [5] = '{16'h0001, 16'h0002, 16'h0100, 16'h0004, 16'hAAAA};
    wr(3'd1, 16'h1000);
    rd(3'd5, v);
    for (int k = 0; k < 5; k++) wr(3'd2, w[k]);
    wr(3'd1, 16'h9000);
    idle(15);
    rd(3'd0, v); chk("R7 length error flagged, nothing exposed", v, 16'h0100);
    rd(3'd5, v); chk("R7 no new-packet event", v, 16'h0060);
    wr(3'd0, 16'h0000);
    rd(3'd0, v); chk("R9 writing zero keeps flag", v, 16'h0100);
    wr(3'd0, 16'h0100);
    rd(3'd0, v); chk("R9 writing one clears flag", v, 16'h0000);
  endtask

  task automatic send12;
    wr(3'd2, 16'h0001); wr(3'd2, 16'h0002); wr(3'd2, 16'h0100); wr(3'd2, 16'd16);
    for (int k = 0; k < 8; k++) wr(3'd2, 16'h0050 + 16'(k));
    wr(3'd1, 16'h9000);
    idle(20);
  endtask

  task automatic test_drop;
    logic [15:0] v;
    wr(3'd1, 16'h1000);
    send12();
    send12();
    rd(3'd0, v); chk("R8 second packet dropped, first kept", v, 16'hA800);
    for (int k = 0; k < 12; k++) begin
      rd(3'd3, v);
      if (k == 3) chk("R8 kept packet length word", v, 16'd16);
      if (k == 11) chk("R8 kept packet final word", v, 16'h0057);
    end
    rd(3'd0, v); chk("R8 dropped packet never exposed", v, 16'h0800);
    wr(3'd0, 16'h0800);
    rd(3'd0, v); chk("R9 drop flag cleared", v, 16'h0000);
  endtask

  task automatic test_stall_full;
    logic [15:0] v;
    wr(3'd1, 16'h0000);
    rd(3'd5, v);
    tx_ready = 1'b0;
    for (int k = 0; k < 16; k++) wr(3'd2, 16'h7000 + 16'(k));
    rd(3'd0, v); chk("R3 buffer full while building", v, 16'h0005);
    wr(3'd2, 16'hDEAD);
    rd(3'd0, v); chk("R3 write into full buffer flags error", v, 16'h000D);
    wr(3'd0, 16'h0008);
    wr(3'd1, 16'h8000);
    rd(3'd0, v); chk("R2 transmitting after flush", v, 16'h0006);
    chk("R2 stalled word valid", {15'd0, tx_valid}, 16'h0001);
    chk("R2 stalled word data", tx_data, 16'h7000);
    chk("R2 stalled word not last", {15'd0, tx_last}, 16'h0000);
    wr(3'd1, 16'h8000);
    rd(3'd0, v); chk("R3 flush while transmitting flags error", v, 16'h000E);
    tx_ready = 1'b1;
    idle(25);
    rd(3'd0, v); chk("R4 disabled receive stores nothing", v, 16'h0008);
    rd(3'd5, v); chk("R10 transmit event only", v, 16'h0060);
    wr(3'd0, 16'h0008);
  endtask

  task automatic test_same_cycle;
    logic [15:0] v;
    logic [15:0] w [6] = '{16'h0003, 16'h0004, 16'h0200, 16'h0004, 16'h3333, 16'h4444};
    wr(3'd1, 16'h1000);
    rd(3'd5, v);
    for (int k = 0; k < 6; k++) wr(3'd2, w[k]);
    wr(3'd1, 16'h9000);
    idle(5);
    rd(3'd5, v); chk("R10 read on completion edge sees old value", v, 16'h0000);
    rd(3'd5, v); chk("R10 events set on read edge survive", v, 16'h01E0);
    for (int k = 0; k < 6; k++) begin
      rd(3'd3, v); chk("R5 packet after same-cycle read", v, w[k]);
    end
  endtask

  initial begin
    rst = 1'b1; cpu_wr = 1'b0; cpu_rd = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    tx_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_loop();
    test_badlen();
    test_drop();
    test_stall_full();
    test_same_cycle();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule